// File: doc/BRIEF.md
# Delayed-Stop Windowed Readout Controller

This block sequences one acquisition of a circular analog sampling memory. While armed, it advances a write pointer through the cells, one cell per clock. A trigger does not freeze the memory at once. The block keeps writing for a programmable number of clocks, then halts the pointer and latches the cell where writing stopped. It then reads out only a window of cells, starting at that stop cell and wrapping past the last cell back to cell 0. Because fewer cells are read, the dead time is shorter.

The readout runs at a slow pace derived from the main clock. Every `RD_DIV` clocks the block presents a cell index together with a one-cycle strobe for an external converter. `busy_o` stays high from the accepted trigger until the last window cell has been presented. When the window is done, the block re-arms writing.

The controller has three states:
- `S_ARMED`: writing, triggers accepted.
- `S_DELAY`: still writing while the delay counts down.
- `S_READ`: writing halted, window being presented.

It has four transitions:
- ARM→DELAY: accepted trigger with a delay greater than zero.
- ARM→READ: accepted trigger with a delay of zero.
- DELAY→READ: the delay has expired.
- READ→ARM: the last window cell has been presented.

Top module: `roi_stop_ctrl`

## Requirements
- R1: In `S_ARMED`, `wr_en_o` is 1 and `wr_ptr_o` advances by one every clock, wrapping from CELLS-1 to 0.
- R2: After a trigger is accepted with delay D>0, `wr_en_o` stays 1 for exactly D further clocks and then drops. `wr_ptr_o` then holds its value until the readout ends.
- R3: With a delay of 0, `wr_en_o` is 0 in the clock cycle right after the trigger cycle.
- R4: `stop_cell_o` equals (write pointer in the trigger cycle + 1 + D) mod CELLS. It holds that value until the next accepted trigger reaches its stop.
- R5: In readout, `rd_strobe_o` pulses for one cycle at a time, with consecutive pulses exactly RD_DIV clocks apart. Pulse k (counting from 0) carries `rd_cell_o` = (stop cell + k) mod CELLS.
- R6: The window length is sampled at trigger acceptance. A value of 0, or a value above CELLS, is treated as CELLS, so exactly that many strobes are issued.
- R7: A trigger that arrives while `busy_o` is 1 is ignored. It changes neither the stop cell nor the strobe count, and it does not start a new acquisition.
- R8: `busy_o` is 1 from the cycle after an accepted trigger until the last strobe. In the cycle of the last strobe, `busy_o` is 0 and `wr_en_o` is 1 again.
- R9: After reset, `busy_o`=0, `wr_en_o`=1, `wr_ptr_o`=0, `stop_cell_o`=0 and `rd_strobe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; the readout pace is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger request, sampled on each clock |
| delay_i | input | DLY_W | Extra write clocks after the trigger before the stop |
| win_len_i | input | IDX_W+2 | Requested window length in cells (0 or >CELLS means CELLS) |
| wr_en_o | output | 1 | The sampling memory is being written |
| wr_ptr_o | output | IDX_W | Cell currently being written |
| stop_cell_o | output | IDX_W | Latched cell where writing halted |
| rd_cell_o | output | IDX_W | Cell index presented to the converter |
| rd_strobe_o | output | 1 | One-cycle strobe: `rd_cell_o` is valid |
| busy_o | output | 1 | An acquisition is in progress; triggers are ignored |

## Verification
The bench builds the block with CELLS=64, DLY_W=8 and RD_DIV=3. At this size a full-window readout takes under 200 clocks, so many events fit in one run. Random delays and stop cells then cross the 63-to-0 boundary often. Requested lengths of up to 80 reach both clamp cases: 0, and values above CELLS. Triggers are injected during the delay and during the readout to confirm they have no effect.

// File: rtl/roi_pkg.sv
package roi_pkg;
    typedef enum logic [1:0] {
        S_ARMED = 2'd0,
        S_DELAY = 2'd1,
        S_READ  = 2'd2
    } roi_state_e;
endpackage

// File: rtl/roi_delay_timer.sv
// Counts down the post-trigger write latency in write-clock cycles.
module roi_delay_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    output logic             last_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == DLY_W'(1));

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/roi_readout_seq.sv
// Paces the window readout: one cell every RD_DIV clocks, from the base cell onwards, wrapping.
module roi_readout_seq #(
    parameter int CELLS  = 1024,
    parameter int RD_DIV = 6,
    localparam int IDX_W = $clog2(CELLS),
    localparam int LEN_W = IDX_W + 2,
    localparam int DIV_W = (RD_DIV > 1) ? $clog2(RD_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] base_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             strobe_o,
    output logic [IDX_W-1:0] cell_o,
    output logic             done_o
);
    logic             active_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] off_q;
    logic             tick;
    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] cell_d;

    assign tick   = active_q && (div_q == DIV_W'(RD_DIV - 1));
    assign done_o = tick && (off_q == len_i - 1'b1);
    assign sum    = {1'b0, base_i} + off_q[IDX_W:0];

    always_comb begin
        if (sum >= (IDX_W+1)'(CELLS)) begin
            cell_d = IDX_W'(sum - (IDX_W+1)'(CELLS));
        end else begin
            cell_d = sum[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            off_q    <= '0;
            strobe_o <= 1'b0;
            cell_o   <= '0;
        end else begin
            strobe_o <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                div_q    <= '0;
                off_q    <= '0;
            end else if (active_q) begin
                if (tick) begin
                    div_q    <= '0;
                    strobe_o <= 1'b1;
                    cell_o   <= cell_d;
                    off_q    <= off_q + 1'b1;
                    if (done_o) begin
                        active_q <= 1'b0;
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
    // R6
    off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (off_q < len_i));
endmodule

// File: rtl/roi_stop_ctrl.sv
module roi_stop_ctrl #(
    parameter int CELLS  = 1024,
    parameter int DLY_W  = 16,
    parameter int RD_DIV = 6,
    localparam int IDX_W = $clog2(CELLS),
    localparam int LEN_W = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [LEN_W-1:0] win_len_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_ptr_o,
    output logic [IDX_W-1:0] stop_cell_o,
    output logic [IDX_W-1:0] rd_cell_o,
    output logic             rd_strobe_o,
    output logic             busy_o
);
    import roi_pkg::*;

    roi_state_e       st_q, st_d;
    logic             accept;
    logic             go_read;
    logic             dly_last;
    logic             rd_done;
    logic [IDX_W-1:0] ptr_q, ptr_nxt;
    logic [IDX_W-1:0] stop_q;
    logic [LEN_W-1:0] len_q, len_clamped;

    assign accept = (st_q == S_ARMED) && trig_i;
    assign go_read = (accept && (delay_i == '0)) || ((st_q == S_DELAY) && dly_last);
    assign ptr_nxt = (ptr_q == IDX_W'(CELLS - 1)) ? '0 : ptr_q + 1'b1;

    always_comb begin
        if (win_len_i == '0 || win_len_i > LEN_W'(CELLS)) begin
            len_clamped = LEN_W'(CELLS);
        end else begin
            len_clamped = win_len_i;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_ARMED: if (accept) st_d = (delay_i == '0) ? S_READ : S_DELAY;
            S_DELAY: if (dly_last) st_d = S_READ;
            S_READ:  if (rd_done) st_d = S_ARMED;
            default: st_d = S_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_ARMED;
        else        st_q <= st_d;
    end

    // Outputs decoded from state
    always_comb begin
        wr_en_o = 1'b0;
        busy_o  = 1'b1;
        unique case (st_q)
            S_ARMED: begin wr_en_o = 1'b1; busy_o = 1'b0; end
            S_DELAY: wr_en_o = 1'b1;
            S_READ:  wr_en_o = 1'b0;
            default: ;
        endcase
    end

    // Write pointer, stop latch, window latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            stop_q <= '0;
            len_q  <= LEN_W'(CELLS);
        end else begin
            if (wr_en_o) ptr_q <= ptr_nxt;
            if (go_read) stop_q <= ptr_nxt;
            if (accept)  len_q <= len_clamped;
        end
    end

    assign wr_ptr_o    = ptr_q;
    assign stop_cell_o = stop_q;

    roi_delay_timer #(.DLY_W(DLY_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .load_val_i(delay_i),
        .last_o    (dly_last)
    );

    roi_readout_seq #(.CELLS(CELLS), .RD_DIV(RD_DIV)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go_read),
        .base_i  (stop_q),
        .len_i   (len_q),
        .strobe_o(rd_strobe_o),
        .cell_o  (rd_cell_o),
        .done_o  (rd_done)
    );

    // R2
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_READ) |=> $stable(ptr_q));
    // R3
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && delay_i == '0) |=> (st_q == S_READ));
    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_read |=> $stable(stop_q));
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DELAY && trig_i && !dly_last) |=> (st_q == S_DELAY));
endmodule

// File: tb/sim_roi_stop_ctrl.sv
module sim_roi_stop_ctrl;
    localparam int CELLS = 64;
    localparam int DLY_W = 8;
    localparam int RD_DIV = 3;
    localparam int IDX_W = $clog2(CELLS);
    localparam int LEN_W = IDX_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [DLY_W-1:0] dly = '0;
    logic [LEN_W-1:0] wlen = '0;
    logic wr_en, strobe, busy;
    logic [IDX_W-1:0] wr_ptr, stop_cell, rd_cell;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    roi_stop_ctrl #(.CELLS(CELLS), .DLY_W(DLY_W), .RD_DIV(RD_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .delay_i(dly), .win_len_i(wlen),
        .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .stop_cell_o(stop_cell),
        .rd_cell_o(rd_cell), .rd_strobe_o(strobe), .busy_o(busy));

    function automatic int exp_len(int l);
        return (l == 0 || l > CELLS) ? CELLS : l;
    endfunction

    function automatic int exp_stop(int p, int d);
        return (p + 1 + d) % CELLS;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One acquisition: trigger with delay d, length l; optional stray triggers while busy.
    task automatic run_event(int d, int l, bit stray);
        int p, es, n, k, last_t, t;
        bit saw_last;
        @(negedge clk);
        // R1: pointer advances while armed
        p = wr_ptr;
        @(negedge clk);
        chk(wr_en && wr_ptr == (p + 1) % CELLS, "R1", wr_ptr, (p + 1) % CELLS);
        p = wr_ptr;
        trig = 1'b1; dly = DLY_W'(d); wlen = LEN_W'(l);
        @(negedge clk);
        trig = 1'b0;
        es = exp_stop(p, d);
        if (d == 0) begin
            chk(!wr_en, "R3", wr_en, 0);
        end
        n = 0;
        while (wr_en && n < 400) begin
            n++;
            if (stray && n == 1) trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        chk(n == d, "R2 write clocks after trigger", n, d);
        chk(stop_cell == es, "R4 stop cell", stop_cell, es);
        chk(busy, "R8 busy during readout", busy, 1);
        k = 0; last_t = -1; t = 0; saw_last = 1'b0;
        while (t < 2000) begin
            if (strobe) begin
                chk(rd_cell == (es + k) % CELLS, "R5 cell index", rd_cell, (es + k) % CELLS);
                if (last_t >= 0) chk(t - last_t == RD_DIV, "R5 spacing", t - last_t, RD_DIV);
                if (!wr_en) chk(wr_ptr == es, "R2 pointer frozen", wr_ptr, es);
                last_t = t;
                k++;
            end
            if (!busy) begin
                saw_last = strobe;
                break;
            end
            if (stray && k == 2 && strobe) trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            t++;
        end
        chk(k == exp_len(l), "R6 strobe count", k, exp_len(l));
        chk(saw_last && wr_en, "R8 re-arm at last strobe", int'(saw_last), 1);
        chk(stop_cell == es, "R7 stop unchanged by stray trigger", stop_cell, es);
        @(negedge clk);
        chk(!busy && !strobe, "R7 no new acquisition", int'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy, "R9 busy", busy, 0);
        chk(wr_en, "R9 wr_en", wr_en, 1);
        chk(wr_ptr == 0, "R9 wr_ptr", wr_ptr, 0);
        chk(stop_cell == 0, "R9 stop", stop_cell, 0);
        chk(!strobe, "R9 strobe", strobe, 0);
        rst_n = 1'b1;
        // Directed corners
        run_event(0, 0, 1'b0);
        run_event(1, 1, 1'b1);
        run_event(0, CELLS, 1'b1);
        run_event(5, 200, 1'b0);
        run_event(2, CELLS + 1, 1'b1);
        // Wrap of write pointer across CELLS-1 while armed (R1)
        repeat (CELLS + 3) @(negedge clk);
        // Random events
        for (int i = 0; i < 25; i++) begin
            run_event(int'($urandom_range(0, 40)), int'($urandom_range(0, 80)), 1'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 70)) @(negedge clk);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule